// File: doc/BRIEF.md
# Nibble Register Serial Master

This block drives a three-pin serial link to a clock chip whose contents sit in 4-bit registers. A user-side request names one register by a 4-bit address and either reads it or writes a 4-bit value into it. The block builds the command bytes, toggles the serial clock, drives or releases the data line, and for reads assembles the incoming bits and returns the low nibble.

A transfer always consists of two bytes of eight clock pulses each, sent most significant bit first. A read sends one command byte and then clocks in one byte. A write sends an address byte followed by a data byte. Each command byte carries flag bits above a 4-bit payload:

- bit 6 marks a read.
- bit 5 marks an address phase.
- bit 4 marks a data phase.

The clock idles high. Each bit has a high (setup) phase and a low phase, and each phase is `HALF_CYCLES` system clocks long. `HALF_CYCLES` is set so that one phase lasts at least 700 ns. The chip-enable pin belongs to a higher-level sequencer, and the block only forwards it.

Top module: `nibreg_serial_master`

## Requirements
- R1: After reset, sclOut is 1, sdaOe is 0, busy is 0, done is 0 and rdNibble is 0.
- R2: Every transfer produces exactly 16 falling edges of sclOut, 8 per byte. Bits go out most significant first, and sdaOut does not change while sclOut is low.
- R3: A read transfer's first byte is {4'b0110, regAddr}: bit 6 is the read flag, bit 5 is the address flag, and bits 3:0 are the address.
- R4: A write transfer sends {4'b0010, regAddr} as the first byte and {4'b0001, wrNibble} as the second byte. Bit 4 is the data flag.
- R5: sdaOe is 1 at every falling edge of a write byte and 0 at every falling edge of a read byte. sdaOe is 0 whenever busy is 0. sdaOe changes only while sclOut is high.
- R6: On a read, sdaIn is sampled in the cycle where sclOut falls, assembled most significant bit first, and bits 3:0 of the result appear on rdNibble when done pulses. Bits 7:4 have no effect.
- R7: sclOut is 1 while idle. Every low phase lasts exactly HALF_CYCLES clock cycles.
- R8: busy is 1 from the cycle after start is accepted until done. done is a single-cycle pulse that coincides with busy falling. A start while busy is ignored and does not alter the transfer in progress.
- R9: pinCe equals ceReq at all times.
- R10: rdNibble changes only at the end of a read and holds its value across write transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| isWrite | input | 1 | 1 = write register, 0 = read register |
| regAddr | input | NIB_W | Register address |
| wrNibble | input | NIB_W | Data for a write |
| ceReq | input | 1 | Chip enable from the sequencer |
| sdaIn | input | 1 | Data line as seen at the pin |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdNibble | output | NIB_W | Last nibble read |
| pinCe | output | 1 | Chip-enable pin |
| sclOut | output | 1 | Serial clock pin |
| sdaOut | output | 1 | Data line output value |
| sdaOe | output | 1 | Data line output enable |

## Verification
An error in the bit counter or the byte index shows up as a wrong number of falling clock edges before done. It also shows up as an output enable that is still active, or already inactive, on the wrong byte. Both are visible within the transfer where the error occurs. A wrong byte selection or a wrong shift direction corrupts the serial bit stream within the first 8 edges. A misplaced sample strobe or publish strobe leaves a wrong rdNibble at the done pulse of the same transfer. Timer faults change the measured length of a low phase on the first bit.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;
  // flag bits placed above the 4-bit payload of each command byte
  localparam logic [7:0] FLAG_READ = 8'h40;
  localparam logic [7:0] FLAG_ADDR = 8'h20;
  localparam logic [7:0] FLAG_DATA = 8'h10;

  typedef enum logic [1:0] {
    SEL_RDCMD  = 2'd0,
    SEL_WRADDR = 2'd1,
    SEL_WRDATA = 2'd2,
    SEL_NONE   = 2'd3
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     loadByte;
    byteSel_e sel;
    logic     shiftBit;
    logic     sampleBit;
    logic     oeOn;
    logic     oeOff;
    logic     publish;
  } dpStrobe_t;
endpackage

// File: rtl/nibreg_dp.sv
module nibreg_dp
  import nibreg_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic [NIB_W-1:0] regAddr,
  input  logic [NIB_W-1:0] wrNibble,
  input  logic             sdaIn,
  output logic             sdaOut,
  output logic             sdaOe,
  output logic [NIB_W-1:0] rdNibble
);
  localparam int PAD_W = BYTE_W - NIB_W;

  logic [NIB_W-1:0]  addrR, dataR;
  logic [BYTE_W-1:0] txShift, rxShift, nextByte;
  logic              oeR;
  logic [NIB_W-1:0]  rdR;

  always_comb begin
    unique case (st.sel)
      SEL_RDCMD:  nextByte = {{PAD_W{1'b0}}, addrR} | FLAG_READ[BYTE_W-1:0] | FLAG_ADDR[BYTE_W-1:0];
      SEL_WRADDR: nextByte = {{PAD_W{1'b0}}, addrR} | FLAG_ADDR[BYTE_W-1:0];
      SEL_WRDATA: nextByte = {{PAD_W{1'b0}}, dataR} | FLAG_DATA[BYTE_W-1:0];
      default:    nextByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR   <= '0;
      dataR   <= '0;
      txShift <= '0;
      rxShift <= '0;
      oeR     <= 1'b0;
      rdR     <= '0;
    end else begin
      if (st.latchReq) begin
        addrR   <= regAddr;
        dataR   <= wrNibble;
        rxShift <= '0;
      end
      if (st.loadByte)       txShift <= nextByte;
      else if (st.shiftBit)  txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (st.sampleBit)      rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      if (st.oeOn)           oeR <= 1'b1;
      else if (st.oeOff)     oeR <= 1'b0;
      if (st.publish)        rdR <= rxShift[NIB_W-1:0];
    end
  end

  assign sdaOut   = txShift[BYTE_W-1];
  assign sdaOe    = oeR;
  assign rdNibble = rdR;
endmodule

// File: rtl/nibreg_ctrl.sv
module nibreg_ctrl
  import nibreg_pkg::*;
#(
  parameter int HALF_CYCLES = 35,
  parameter int BYTE_W      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      isWrite,
  output dpStrobe_t st,
  output logic      sclOut,
  output logic      busy,
  output logic      done
);
  localparam int TMR_W = $clog2(HALF_CYCLES + 1);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(BYTE_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SETUP, S_LOW} state_e;

  state_e           state;
  logic [TMR_W-1:0] timer;
  logic [BIT_W-1:0] bitCnt;
  logic             byteNum;
  logic             wrR;
  logic             sclR, doneR;
  logic             halfEnd, lastBit, rdPhase;

  assign halfEnd = (timer == TMR_END);
  assign lastBit = (bitCnt == BIT_END);
  assign rdPhase = byteNum && !wrR;

  always_comb begin
    st     = '0;
    st.sel = SEL_NONE;
    unique case (state)
      S_IDLE:  st.latchReq = start;
      S_LOAD: begin
        st.loadByte = 1'b1;
        st.oeOn     = !rdPhase;
        if (!byteNum)  st.sel = wrR ? SEL_WRADDR : SEL_RDCMD;
        else if (wrR)  st.sel = SEL_WRDATA;
      end
      S_SETUP: st.sampleBit = halfEnd && rdPhase;
      S_LOW: begin
        if (halfEnd) begin
          st.shiftBit = !lastBit;
          st.oeOff    = lastBit;
          st.publish  = lastBit && rdPhase;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      timer   <= '0;
      bitCnt  <= '0;
      byteNum <= 1'b0;
      wrR     <= 1'b0;
      sclR    <= 1'b1;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          wrR     <= isWrite;
          byteNum <= 1'b0;
          state   <= S_LOAD;
        end
        S_LOAD: begin
          timer  <= '0;
          bitCnt <= '0;
          state  <= S_SETUP;
        end
        S_SETUP: begin
          if (halfEnd) begin
            timer <= '0;
            sclR  <= 1'b0;
            state <= S_LOW;
          end else timer <= timer + 1'b1;
        end
        S_LOW: begin
          if (halfEnd) begin
            timer <= '0;
            sclR  <= 1'b1;
            if (!lastBit) begin
              bitCnt <= bitCnt + 1'b1;
              state  <= S_SETUP;
            end else if (!byteNum) begin
              byteNum <= 1'b1;
              state   <= S_LOAD;
            end else begin
              doneR <= 1'b1;
              state <= S_IDLE;
            end
          end else timer <= timer + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sclOut = sclR;
  assign busy   = (state != S_IDLE);
  assign done   = doneR;
endmodule

// File: rtl/nibreg_serial_master.sv
module nibreg_serial_master
  import nibreg_pkg::*;
#(
  parameter int HALF_CYCLES = 35,
  parameter int NIB_W       = 4,
  parameter int BYTE_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isWrite,
  input  logic [NIB_W-1:0] regAddr,
  input  logic [NIB_W-1:0] wrNibble,
  input  logic             ceReq,
  input  logic             sdaIn,
  output logic             busy,
  output logic             done,
  output logic [NIB_W-1:0] rdNibble,
  output logic             pinCe,
  output logic             sclOut,
  output logic             sdaOut,
  output logic             sdaOe
);
  dpStrobe_t st;

  nibreg_ctrl #(.HALF_CYCLES(HALF_CYCLES), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .st(st), .sclOut(sclOut), .busy(busy), .done(done)
  );

  nibreg_dp #(.NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .regAddr(regAddr), .wrNibble(wrNibble),
    .sdaIn(sdaIn), .sdaOut(sdaOut), .sdaOe(sdaOe), .rdNibble(rdNibble)
  );

  assign pinCe = ceReq;
endmodule

// File: rtl/nibreg_checker.sv
module nibreg_checker #(
  parameter int HALF_CYCLES = 35,
  parameter int NIB_W       = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             sclOut,
  input logic             sdaOut,
  input logic             sdaOe,
  input logic [NIB_W-1:0] rdNibble
);
  localparam int CNT_W = $clog2(HALF_CYCLES + 2);
  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        lowCnt <= '0;
    else if (sclOut)  lowCnt <= '0;
    else              lowCnt <= lowCnt + 1'b1;
  end

  p_low_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOut) |-> (lowCnt == CNT_W'(HALF_CYCLES)));
  p_scl_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclOut);
  p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdaOe);
  p_oe_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> sclOut);
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOut && $past(!sclOut)) |-> $stable(sdaOut));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(rdNibble));
endmodule

bind nibreg_serial_master nibreg_checker #(.HALF_CYCLES(HALF_CYCLES), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .sclOut(sclOut),
  .sdaOut(sdaOut), .sdaOe(sdaOe), .rdNibble(rdNibble)
);

// File: tb/nibreg_serial_master_tb.sv
module nibreg_serial_master_tb;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0, isWrite = 1'b0, ceReq = 1'b0, sdaIn = 1'b0;
  logic [3:0] regAddr = '0, wrNibble = '0;
  logic       busy, done, pinCe, sclOut, sdaOut, sdaOe;
  logic [3:0] rdNibble;

  int checks = 0, fails = 0;
  int fallCnt = 0, lowLen = 0, lowErr = 0;
  logic prevScl = 1'b1;
  logic [15:0] txBits, oeBits;
  logic [7:0]  rdPat = '0;
  logic [3:0]  lastRd = '0;

  always #10 clk = ~clk;

  nibreg_serial_master #(.HALF_CYCLES(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .regAddr(regAddr),
    .wrNibble(wrNibble), .ceReq(ceReq), .sdaIn(sdaIn), .busy(busy), .done(done),
    .rdNibble(rdNibble), .pinCe(pinCe), .sclOut(sclOut), .sdaOut(sdaOut), .sdaOe(sdaOe)
  );

  // device-side model: records bits at each falling clock, feeds read data
  always @(negedge clk) begin
    if (rstN) begin
      if (prevScl && !sclOut) begin
        if (fallCnt < 16) begin
          txBits[15-fallCnt] = sdaOut;
          oeBits[15-fallCnt] = sdaOe;
        end
        fallCnt++;
        if (fallCnt >= 8 && fallCnt < 16) sdaIn = rdPat[15-fallCnt];
        lowLen = 1;
      end else if (!sclOut) lowLen++;
      if (!prevScl && sclOut && lowLen != HALF) lowErr++;
      prevScl = sclOut;
    end
  end

  function automatic logic [7:0] expFirst(input logic wr, input logic [3:0] a);
    return wr ? {4'b0010, a} : {4'b0110, a};
  endfunction
  function automatic logic [7:0] expSecond(input logic [3:0] d);
    return {4'b0001, d};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doTxn(input logic wr, input logic [3:0] a, input logic [3:0] d,
                       input logic [7:0] pat, input bit spur);
    bit seen = 0;
    @(negedge clk);
    fallCnt = 0; lowErr = 0; txBits = '0; oeBits = '0;
    rdPat = pat; sdaIn = 1'b0;
    isWrite = wr; regAddr = a; wrNibble = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (spur && i == 20) begin
        isWrite = ~wr; regAddr = ~a; wrNibble = ~d; start = 1'b1;
      end else start = 1'b0;
      if (done) begin seen = 1; break; end
    end
    start = 1'b0;
    check(seen, "R8 done seen", seen, 1);
    check(busy == 1'b0, "R8 busy low at done", busy, 0);
    check(fallCnt == 16, "R2 falling edge count", fallCnt, 16);
    check(lowErr == 0, "R7 low phase length", lowErr, 0);
    check(sclOut == 1'b1 && sdaOe == 1'b0, "R7/R5 idle pins", {sclOut, sdaOe}, 2'b10);
    check(txBits[15:8] == expFirst(wr, a), wr ? "R4 address byte" : "R3 read command byte",
          txBits[15:8], expFirst(wr, a));
    if (wr) begin
      check(txBits[7:0] == expSecond(d), "R4 data byte", txBits[7:0], expSecond(d));
      check(oeBits == 16'hFFFF, "R5 oe on write bytes", oeBits, 16'hFFFF);
      check(rdNibble == lastRd, "R10 rdNibble held over write", rdNibble, lastRd);
    end else begin
      check(oeBits == 16'hFF00, "R5 oe on command then released", oeBits, 16'hFF00);
      lastRd = pat[3:0];
      check(rdNibble == pat[3:0], "R6 read nibble", rdNibble, pat[3:0]);
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done single pulse", done, 0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sclOut == 1'b1, "R1 scl after reset", sclOut, 1);
    check(sdaOe == 1'b0, "R1 oe after reset", sdaOe, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", {busy, done}, 0);
    check(rdNibble == 4'h0, "R1 rdNibble after reset", rdNibble, 0);
    // R9 chip enable forwarding
    ceReq = 1'b1; #1;
    check(pinCe == 1'b1, "R9 ce high", pinCe, 1);
    ceReq = 1'b0; #1;
    check(pinCe == 1'b0, "R9 ce low", pinCe, 0);
    ceReq = 1'b1;
    // directed corners
    doTxn(1'b0, 4'hF, 4'h0, 8'hA5, 1'b0);   // R6 upper bits ignored
    doTxn(1'b1, 4'h0, 4'hF, 8'h00, 1'b0);   // R4, R10
    doTxn(1'b0, 4'h0, 4'h0, 8'hF0, 1'b0);   // R6 upper set, nibble zero
    doTxn(1'b1, 4'hE, 4'h4, 8'h00, 1'b1);   // R8 start while busy ignored
    doTxn(1'b0, 4'h7, 4'h0, 8'h0F, 1'b1);
    // random mix
    for (int n = 0; n < 40; n++) begin
      doTxn(1'($urandom), 4'($urandom), 4'($urandom), 8'($urandom), 1'($urandom % 4 == 0));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule